// File: doc/BRIEF.md
# Indirect Register Port with Auto-Increment

This block is the host side of a small bus-adapter controller's register space. The host reaches every register through two doors. It first writes an index into a pointer through the address door. It then reads or writes bytes through the data door, and after each access the pointer steps to the next index on its own. Behind the doors are a 32-entry byte register file, a 24-bit transfer count that the host sees as three byte registers, and a latched copy of the controller's own bus ID.

The command engine is a separate block. It receives one-cycle strobes from this block for command bytes, data-register traffic and status reads. It can also update any register through a side write port, and it counts the transfer down with a decrement strobe. A peek path returns register contents without touching any state, so a debugger can read the space safely.

Top module: `idxp_top`

## Requirements
- R1: A single `addr_we` strobe loads the pointer from `wdata[4:0]`, so the next data access goes to that index. The upper three bits are ignored.
- R2: After a single data-door read or write, the pointer advances by one and wraps from 0x1F to 0x00. A read at 0x1F also advances and wraps to 0x00.
- R3: A data write at index 0x18 does not go into the register file. Instead, one cycle later, `cmd_we` pulses for one cycle with `cmd_byte` equal to the written byte. Reads and writes at 0x18 leave the pointer where it is.
- R4: A data write at index 0x1F (aux status) changes nothing and leaves the pointer where it is.
- R5: Indices 0x12, 0x13 and 0x14 are the high, middle and low bytes of one live 24-bit count. A write replaces only its own byte. A read returns the matching byte of the current count. `xfer_dec` lowers the count by one, modulo 2^24, except in a cycle with a host count write, where the write wins.
- R6: A data write at index 0x00 stores the byte, and `bus_id` becomes bits [2:0] of it on the next cycle.
- R7: A data write at 0x17 or at 0x1A to 0x1E is not stored, but the pointer still advances.
- R8: After reset, indices 0x00–0x1A read 0x00, 0x1B–0x1E read 0xFF, 0x1F reads 0x80, and the pointer, the count and `bus_id` are zero.
- R9: `peek_data` returns index 0x1F when `peek_sel` is 0. When `peek_sel` is 1 it returns whatever a data read would return at the pointer. Peeking changes no state.
- R10: If more than one of `addr_we`, `data_we` and `data_re` is high in a cycle, the cycle has no effect: the pointer and registers do not change and no forward strobe is sent.
- R11: Forward strobes are registered one-cycle pulses. `data_wr_fwd` follows a data write at 0x19, and that write is also stored. `data_rd_fwd` follows a data read at 0x19. `status_rd_fwd` follows a data read at 0x17.
- R12: An `ext_we` write from the command engine stores `ext_wdata` at `ext_addr`. A host data write to the same index in the same cycle takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Address-door write strobe |
| data_we | input | 1 | Data-door write strobe |
| data_re | input | 1 | Data-door read strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Combinational read byte at the pointer |
| peek_sel | input | 1 | Peek selector: 0 aux status, 1 pointed register |
| peek_data | output | 8 | Side-effect-free read byte |
| ext_we | input | 1 | Command-engine register write strobe |
| ext_addr | input | 5 | Command-engine write index |
| ext_wdata | input | 8 | Command-engine write byte |
| xfer_dec | input | 1 | Decrement transfer count by one |
| bus_id | output | 3 | Latched own bus ID |
| cmd_we | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| data_wr_fwd | output | 1 | Data register written |
| data_rd_fwd | output | 1 | Data register read |
| status_rd_fwd | output | 1 | Status register read |

## Verification
The pointer is exercised with plain sequential writes, with address bytes whose upper bits are set, and with walks past 0x1F. Together these separate a correct 5-bit wrap from a wider or truncated pointer. The count is loaded one byte at a time through auto-increment and then decremented across a byte borrow, which separates byte-lane replacement from whole-word writes and shows that the borrow carries. Writes and reads at the held indices (0x18, 0x1F) and at the non-stored indices are followed by reads of the neighbouring index. This shows whether the pointer moved, separately from whether the byte was kept. Colliding strobes and repeated peeks show that nothing changes when it should not.

// File: rtl/idxp_pkg.sv
package idxp_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 24;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] IX_OWN    = 5'h00;
  localparam logic [ADDR_W-1:0] IX_CNT_HI = 5'h12;
  localparam logic [ADDR_W-1:0] IX_CNT_LO = 5'h14;
  localparam logic [ADDR_W-1:0] IX_GEN_HI = 5'h16;
  localparam logic [ADDR_W-1:0] IX_STAT   = 5'h17;
  localparam logic [ADDR_W-1:0] IX_CMD    = 5'h18;
  localparam logic [ADDR_W-1:0] IX_DATA   = 5'h19;
  localparam logic [ADDR_W-1:0] IX_ZERO_HI = 5'h1A;
  localparam logic [ADDR_W-1:0] IX_AUX    = 5'h1F;

  localparam logic [DATA_W-1:0] AUX_RST = 8'h80;

  function automatic logic [DATA_W-1:0] reset_val(input int idx);
    if (idx == int'(IX_AUX))          return AUX_RST;
    else if (idx > int'(IX_ZERO_HI))  return '1;
    else                              return '0;
  endfunction
endpackage

// File: rtl/idxp_pointer.sv
module idxp_pointer #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/idxp_regfile.sv
module idxp_regfile
  import idxp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int N = 1 << AW;

  logic [N*DW-1:0] flat;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [DW-1:0] q;
    logic hit_h, hit_e;
    assign hit_h = h_we && (h_addr == AW'(i));
    assign hit_e = e_we && (e_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)        q <= reset_val(i);
      else if (hit_h) q <= h_wdata;
      else if (hit_e) q <= e_wdata;
    end
    assign flat[i*DW +: DW] = q;
  end

  assign ra_data = flat[ra_addr*DW +: DW];
  assign rb_data = flat[rb_addr*DW +: DW];
endmodule

// File: rtl/idxp_xfer_count.sv
module idxp_xfer_count #(
  parameter int CW = 24,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lane_we,
  input  logic [$clog2(CW/DW)-1:0] lane_sel,
  input  logic [DW-1:0]         lane_wdata,
  input  logic                  dec,
  input  logic [$clog2(CW/DW)-1:0] rd_lane,
  output logic [DW-1:0]         rd_byte,
  output logic [CW-1:0]         count
);
  localparam int LANES = CW / DW;
  localparam int LW    = $clog2(LANES);

  logic [CW-1:0] base;
  assign base = (dec && !lane_we) ? count - CW'(1) : count;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        count[l*DW +: DW] <= '0;
      else if (lane_we && lane_sel == LW'(l))
        count[l*DW +: DW] <= lane_wdata;
      else
        count[l*DW +: DW] <= base[l*DW +: DW];
    end
  end

  assign rd_byte = count[rd_lane*DW +: DW];
endmodule

// File: rtl/idxp_top.sv
module idxp_top
  import idxp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          peek_sel,
  output logic [DW-1:0] peek_data,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  input  logic          xfer_dec,
  output logic [2:0]    bus_id,
  output logic          cmd_we,
  output logic [DW-1:0] cmd_byte,
  output logic          data_wr_fwd,
  output logic          data_rd_fwd,
  output logic          status_rd_fwd
);
  localparam int LANES = CW / DW;
  localparam int LW    = $clog2(LANES);

  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic          one_hot, h_aw, h_dw, h_dr;
  logic          at_cmd, at_aux, at_cnt, at_data, at_stat, storable;
  logic          adv, rf_we, cnt_we;
  logic [LW-1:0] lane;
  logic [DW-1:0] rf_a, rf_aux, cnt_byte, ptr_view;

  // decode of host strobes
  assign one_hot = $countones({addr_we, data_we, data_re}) == 1;
  assign h_aw    = addr_we && one_hot;
  assign h_dw    = data_we && one_hot;
  assign h_dr    = data_re && one_hot;

  assign at_cmd  = ptr_q == IX_CMD;
  assign at_aux  = ptr_q == IX_AUX;
  assign at_data = ptr_q == IX_DATA;
  assign at_stat = ptr_q == IX_STAT;
  assign at_cnt  = (ptr_q >= IX_CNT_HI) && (ptr_q <= IX_CNT_LO);
  assign storable = ((ptr_q <= IX_GEN_HI) && !at_cnt) || at_data;

  assign adv    = (h_dw && !at_cmd && !at_aux) || (h_dr && !at_cmd);
  assign rf_we  = h_dw && storable;
  assign cnt_we = h_dw && at_cnt;
  assign lane   = LW'(IX_CNT_LO - ptr_q);

  idxp_pointer #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (h_aw),
    .load_val(wdata[AW-1:0]),
    .adv     (adv),
    .ptr     (ptr_q)
  );

  idxp_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .h_we   (rf_we),
    .h_addr (ptr_q),
    .h_wdata(wdata),
    .e_we   (ext_we),
    .e_addr (ext_addr),
    .e_wdata(ext_wdata),
    .ra_addr(ptr_q),
    .ra_data(rf_a),
    .rb_addr(IX_AUX),
    .rb_data(rf_aux)
  );

  idxp_xfer_count #(.CW(CW), .DW(DW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .lane_we   (cnt_we),
    .lane_sel  (lane),
    .lane_wdata(wdata),
    .dec       (xfer_dec),
    .rd_lane   (lane),
    .rd_byte   (cnt_byte),
    .count     (cnt_q)
  );

  assign ptr_view  = at_cnt ? cnt_byte : rf_a;
  assign rdata     = ptr_view;
  assign peek_data = peek_sel ? ptr_view : rf_aux;

  // registered side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_id        <= '0;
      cmd_we        <= 1'b0;
      cmd_byte      <= '0;
      data_wr_fwd   <= 1'b0;
      data_rd_fwd   <= 1'b0;
      status_rd_fwd <= 1'b0;
    end else begin
      if (h_dw && ptr_q == IX_OWN) bus_id <= wdata[2:0];
      cmd_we        <= h_dw && at_cmd;
      if (h_dw && at_cmd) cmd_byte <= wdata;
      data_wr_fwd   <= h_dw && at_data;
      data_rd_fwd   <= h_dr && at_data;
      status_rd_fwd <= h_dr && at_stat;
    end
  end
endmodule

// File: rtl/idxp_chk.sv
module idxp_chk (
  input logic        clk,
  input logic        rst,
  input logic        addr_we,
  input logic        data_we,
  input logic        data_re,
  input logic [7:0]  wdata,
  input logic [4:0]  ptr_q,
  input logic [23:0] cnt_q,
  input logic        xfer_dec,
  input logic [2:0]  bus_id,
  input logic        cmd_we,
  input logic [7:0]  cmd_byte
);
  logic solo_a, solo_w, multi;
  assign solo_a = addr_we && !data_we && !data_re;
  assign solo_w = data_we && !addr_we && !data_re;
  assign multi  = $countones({addr_we, data_we, data_re}) > 1;

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    solo_a |=> ptr_q == $past(wdata[4:0]));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (solo_w && ptr_q != 5'h18 && ptr_q != 5'h1F) |=> ptr_q == $past(ptr_q) + 5'd1);

  // R3
  cmd_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (solo_w && ptr_q == 5'h18) |=> cmd_we && cmd_byte == $past(wdata) && $stable(ptr_q));

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    multi |=> $stable(ptr_q) && !cmd_we);

  // R6
  own_id_chk: assert property (@(posedge clk) disable iff (rst)
    (solo_w && ptr_q == 5'h00) |=> bus_id == $past(wdata[2:0]));

  // R5
  count_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_dec && !data_we) |=> cnt_q == $past(cnt_q) - 24'd1);
endmodule

bind idxp_top idxp_chk u_chk (.*);

// File: tb/idxp_top_tb.sv
module idxp_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_we = 0, data_we = 0, data_re = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       peek_sel = 0;
  logic [7:0] peek_data;
  logic       ext_we = 0;
  logic [4:0] ext_addr = 0;
  logic [7:0] ext_wdata = 0;
  logic       xfer_dec = 0;
  logic [2:0] bus_id;
  logic       cmd_we;
  logic [7:0] cmd_byte;
  logic       data_wr_fwd, data_rd_fwd, status_rd_fwd;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  idxp_top u_dut (
    .clk(clk), .rst(rst), .addr_we(addr_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rdata(rdata), .peek_sel(peek_sel), .peek_data(peek_data),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .xfer_dec(xfer_dec),
    .bus_id(bus_id), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .data_wr_fwd(data_wr_fwd), .data_rd_fwd(data_rd_fwd), .status_rd_fwd(status_rd_fwd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); addr_we = 1; wdata = a;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); data_we = 1; wdata = d;
    @(negedge clk); data_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    @(negedge clk); data_re = 1; #1;
    check(req, rdata, exp);
    @(negedge clk); data_re = 0;
  endtask

  task automatic ext_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); ext_we = 1; ext_addr = a; ext_wdata = d;
    @(negedge clk); ext_we = 0;
  endtask

  task automatic peek(input string req, input logic s, input logic [7:0] exp);
    @(negedge clk); peek_sel = s; #1;
    check(req, peek_data, exp);
  endtask

  task automatic t_reset;
    peek("R8 aux after reset", 0, 8'h80);
    peek("R8 ptr zero reg0", 1, 8'h00);
    check("R8 bus_id", bus_id, 0);
    set_addr(8'h1B); peek("R8 0x1B", 1, 8'hFF);
    set_addr(8'h1E); peek("R8 0x1E", 1, 8'hFF);
    set_addr(8'h1A); peek("R8 0x1A", 1, 8'h00);
    set_addr(8'h13); peek("R8 count byte", 1, 8'h00);
  endtask

  task automatic t_pointer;
    set_addr(8'hE3);
    wr(8'h5A); wr(8'h6B);
    set_addr(8'h03);
    rd("R1 upper addr bits ignored", 8'h5A);
    rd("R2 auto-increment read", 8'h6B);
    set_addr(8'h1E);
    rd("R2 read 0x1E", 8'hFF);
    rd("R2 read 0x1F", 8'h80);
    rd("R2 wrap to 0x00", 8'h00);
    peek("R2 ptr now 0x01", 1, 8'h00);
  endtask

  task automatic t_command;
    ext_wr(5'h18, 8'h33);
    ext_wr(5'h19, 8'h44);
    set_addr(8'h18);
    wr(8'h09);
    check("R3 cmd_we pulse", cmd_we, 1);
    check("R3 cmd_byte", cmd_byte, 8'h09);
    peek("R3 not stored, ptr held", 1, 8'h33);
    @(negedge clk); check("R3 pulse one cycle", cmd_we, 0);
    rd("R3 read 0x18", 8'h33);
    rd("R3 read 0x18 again held", 8'h33);
    wr(8'h0A);
    check("R3 second cmd", cmd_byte, 8'h0A);
  endtask

  task automatic t_aux;
    set_addr(8'h1F);
    wr(8'h00);
    peek("R4 aux unchanged", 0, 8'h80);
    peek("R4 ptr held at 0x1F", 1, 8'h80);
    ext_wr(5'h1F, 8'hC1);
    peek("R12 ext write aux", 0, 8'hC1);
  endtask

  task automatic t_count;
    set_addr(8'h12);
    wr(8'h01); wr(8'h02); wr(8'h03);
    set_addr(8'h12);
    rd("R5 count hi", 8'h01); rd("R5 count mid", 8'h02); rd("R5 count lo", 8'h03);
    @(negedge clk); xfer_dec = 1;
    @(negedge clk); xfer_dec = 0;
    set_addr(8'h14); peek("R5 dec lo", 1, 8'h02);
    set_addr(8'h13); wr(8'h00); wr(8'h00);
    set_addr(8'h12); peek("R5 hi kept on mid write", 1, 8'h01);
    @(negedge clk); xfer_dec = 1;
    @(negedge clk); xfer_dec = 0;
    rd("R5 borrow hi", 8'h00); rd("R5 borrow mid", 8'hFF); rd("R5 borrow lo", 8'hFF);
    set_addr(8'h14);
    @(negedge clk); data_we = 1; wdata = 8'h40; xfer_dec = 1;
    @(negedge clk); data_we = 0; xfer_dec = 0;
    set_addr(8'h14); peek("R5 write beats dec", 1, 8'h40);
  endtask

  task automatic t_own;
    set_addr(8'h00);
    wr(8'hAD);
    check("R6 bus_id", bus_id, 3'd5);
    set_addr(8'h00); rd("R6 reg0 stored", 8'hAD);
  endtask

  task automatic t_nostore;
    set_addr(8'h1A);
    wr(8'h77);
    peek("R7 ptr advanced to 0x1B", 1, 8'hFF);
    set_addr(8'h1A); peek("R7 0x1A not stored", 1, 8'h00);
    ext_wr(5'h17, 8'h11);
    set_addr(8'h17); wr(8'h99);
    peek("R7 past 0x17 to 0x18", 1, 8'h33);
    set_addr(8'h17); peek("R7 0x17 not stored", 1, 8'h11);
  endtask

  task automatic t_forward;
    set_addr(8'h19);
    wr(8'h5C);
    check("R11 data_wr_fwd", data_wr_fwd, 1);
    set_addr(8'h19);
    rd("R11 data stored", 8'h5C);
    check("R11 data_rd_fwd", data_rd_fwd, 1);
    set_addr(8'h17);
    rd("R11 status read value", 8'h11);
    check("R11 status_rd_fwd", status_rd_fwd, 1);
    check("R11 no data_rd_fwd on status", data_rd_fwd, 0);
    set_addr(8'h19);
    @(negedge clk); data_we = 1; wdata = 8'hE7; ext_we = 1; ext_addr = 5'h19; ext_wdata = 8'h12;
    @(negedge clk); data_we = 0; ext_we = 0;
    set_addr(8'h19); peek("R12 host beats ext", 1, 8'hE7);
  endtask

  task automatic t_collide;
    set_addr(8'h05);
    @(negedge clk); addr_we = 1; data_we = 1; wdata = 8'h18;
    @(negedge clk); addr_we = 0; data_we = 0;
    check("R10 no cmd", cmd_we, 0);
    peek("R10 ptr and reg5 unchanged", 1, 8'h00);
    @(negedge clk); data_we = 1; data_re = 1; wdata = 8'h3C;
    @(negedge clk); data_we = 0; data_re = 0;
    rd("R10 reg5 still zero", 8'h00);
    rd("R10 ptr had stayed at 5", 8'h00);
  endtask

  task automatic t_peek;
    set_addr(8'h00);
    peek("R9 peek pointed", 1, 8'hAD);
    peek("R9 peek pointed again", 1, 8'hAD);
    peek("R9 peek aux", 0, 8'hC1);
    rd("R9 peek left ptr", 8'hAD);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_pointer();
    t_command();
    t_aux();
    t_count();
    t_own();
    t_nostore();
    t_forward();
    t_collide();
    t_peek();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule